// File: doc/BRIEF.md
# Configuration Access Sequencer with Sub-Word Merge

This block sits between a configuration requester and a bridge port that can only move whole 32-bit words. A request names a bus, a device/function number, a register offset, an access size (byte, halfword or word), a direction and write data. The block turns that request into a fixed series of register transactions on the port. The port has an address register and a data register. The block first writes a packed address word into the address register, then reads or writes the data register.

Reads of less than a word take the addressed lane or lanes out of the returned word and right-justify them. Writes of less than a word are done as a read of the whole word. The new lane or lanes are then merged in, and the whole word is written back, with a fresh address write before each data step. Requests outside the reachable target range never reach the port and complete at once with a not-found flag. A data read that ends in an error, or that gets no answer within a bounded number of cycles, yields all ones instead of a fault.

While a sequence is on the port, a select output is pulled away from its resting level. New requests are held off until the final transaction completes and a one-cycle completion pulse is given.

Top module: `cfg_access_seq`

## Requirements
- R1: Every in-range access starts with a write to the address register (port offset 0x500), followed by a transfer at the data register (port offset 0x504). An in-range read or word write makes exactly these two port transactions.
- R2: The address word carries the bus number in bits 23:16, device/function in bits 15:8, and offset bits 7:2 in bits 7:2. Bits 31:24 and bit 1 are zero.
- R3: Bit 0 of the address word is 0 when the bus number is 0 and 1 for any other bus.
- R4: A request with bus above 7 or device/function above 127 makes no port transaction. It completes on the cycle after acceptance with the not-found flag set. A read of this kind returns 0xFF for a byte, 0xFFFF for a halfword or 0xFFFFFFFF for a word.
- R5: Size code 0 is a byte. A byte read at offset o returns bits 8*(o mod 4)+7 down to 8*(o mod 4) of the word in bits 7:0 of the read data, with the upper bits zero.
- R6: Size code 1 is a halfword. A halfword read returns bits 31:16 of the word when offset bit 1 is set and bits 15:0 when it is clear, in the low 16 bits of the read data.
- R7: A byte or halfword write makes four transactions: address write, data read, address write, data write. The word written back equals the word read with only the addressed lane or lanes replaced by the low bits of the write data.
- R8: When a data read ends with the port error flag, or sees no acknowledge within 16 cycles, the word is taken as all ones before lane extraction.
- R9: The select output rests high. It is low in every cycle in which a port transaction is requested, and high again on the completion cycle.
- R10: Ready is high only when idle. It stays low from acceptance until the completion pulse, which lasts exactly one cycle.
- R11: Size codes 2 and 3 are a word access, which ignores offset bits 1:0. A halfword access ignores offset bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle and able to accept |
| req_write | input | 1 | 1 for write, 0 for read |
| req_size | input | 2 | 0 byte, 1 halfword, 2 or 3 word |
| req_bus | input | 8 | Target bus number |
| req_devfn | input | 8 | Target device/function number |
| req_offset | input | 8 | Configuration register byte offset |
| req_wdata | input | 32 | Write data, right-justified for sub-word sizes |
| done | output | 1 | One-cycle completion pulse |
| done_notfound | output | 1 | Target out of range, valid with done |
| done_rdata | output | 32 | Read result, right-justified, valid with done |
| sel_normal | output | 1 | Select line, low while a sequence owns the port |
| port_req | output | 1 | Port transaction request, held until acknowledge |
| port_write | output | 1 | Port transaction direction |
| port_addr | output | 12 | Port register offset |
| port_wdata | output | 32 | Port write data |
| port_ack | input | 1 | Port transaction complete |
| port_err | input | 1 | Port transaction failed, valid with ack |
| port_rdata | input | 32 | Port read data, valid with ack |

## Verification
On every cycle, the assertions check the following. A port sequence always opens with an address-register write. Each address word has zero reserved bits and a type bit that matches its bus field. The select line is low whenever the port is requested, and ready is low while the select is off. The completion pulse lasts one cycle, and an out-of-range request is turned away without traffic. Other properties depend on the data and can only be shown by the bench: lane extraction at each offset and size, the merged write-back word, the exact count and order of port transactions, and the all-ones substitution after an error or a missing acknowledge. The bench sweeps all sizes and offsets against a register model of the port.

// File: rtl/cfg_seq_pkg.sv
// Shared types and fixed field widths for the configuration access sequencer.
// Assumes a 32-bit port word with four byte lanes.
package cfg_seq_pkg;

    localparam int BUS_W   = 8;
    localparam int DEVFN_W = 8;
    localparam int OFS_W   = 8;
    localparam int DATA_W  = 32;
    localparam int LANES   = DATA_W / 8;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2
    } cfg_size_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_DATA,
        ST_ADDR2,
        ST_DATA2,
        ST_FIN
    } seq_state_e;

endpackage

// File: rtl/cfg_target_decode.sv
// Range check and address-word packing for one request.
// Assumes the offset's two low bits are dropped (whole-word cycles only).
module cfg_target_decode
    import cfg_seq_pkg::*;
#(
    parameter int BUS_MAX   = 7,
    parameter int DEVFN_MAX = 127
) (
    input  logic [BUS_W-1:0]   bus,
    input  logic [DEVFN_W-1:0] devfn,
    input  logic [OFS_W-1:0]   offset,
    output logic               in_range,
    output logic [DATA_W-1:0]  addr_word
);

    localparam int PAD_W = DATA_W - BUS_W - DEVFN_W - OFS_W;

    // Reachable-target check on both fields.
    always_comb begin
        in_range = (int'(bus) <= BUS_MAX) && (int'(devfn) <= DEVFN_MAX);
    end

    // Pack fields; nonzero bus selects the forwarded (type 1) form.
    always_comb begin
        addr_word = {{PAD_W{1'b0}}, bus, devfn, offset[OFS_W-1:2], 1'b0, (bus != '0)};
    end

endmodule

// File: rtl/cfg_lane_unit.sv
// Byte-lane extraction for sub-word reads and lane merge for sub-word writes.
// Assumes lane 0 is bits 7:0 and offset bits 1:0 pick the lane directly.
module cfg_lane_unit
    import cfg_seq_pkg::*;
(
    input  cfg_size_e          size,
    input  logic [1:0]         ofs,
    input  logic [DATA_W-1:0]  word_in,
    input  logic [DATA_W-1:0]  new_data,
    output logic [DATA_W-1:0]  rd_extract,
    output logic [DATA_W-1:0]  merged
);

    logic [LANES-1:0] lane_en;

    // Right-justify the addressed lane(s) of the incoming word.
    always_comb begin
        case (size)
            SZ_BYTE: rd_extract = (word_in >> {ofs, 3'b000}) & 32'h0000_00FF;
            SZ_HALF: rd_extract = (word_in >> {ofs[1], 4'b0000}) & 32'h0000_FFFF;
            default: rd_extract = word_in;
        endcase
    end

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        localparam logic [1:0] LI = 2'(g);
        logic [7:0] src;

        // Lane enable and source byte for this lane at the given size.
        always_comb begin
            case (size)
                SZ_BYTE: begin
                    lane_en[g] = (ofs == LI);
                    src        = new_data[7:0];
                end
                SZ_HALF: begin
                    lane_en[g] = (ofs[1] == LI[1]);
                    src        = new_data[8*(g%2) +: 8];
                end
                default: begin
                    lane_en[g] = 1'b1;
                    src        = new_data[8*g +: 8];
                end
            endcase
        end

        assign merged[8*g +: 8] = lane_en[g] ? src : word_in[8*g +: 8];
    end

endmodule

// File: rtl/cfg_phase_timer.sv
// Counts wait cycles of one port phase and flags a missing acknowledge.
// Assumes the phase ends on ack or expiry, and restarts at zero afterward.
module cfg_phase_timer #(
    parameter int LIMIT = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic active,
    input  logic ack,
    output logic expired
);

    localparam int CW = $clog2(LIMIT + 1);

    logic [CW-1:0] cnt;

    assign expired = active && !ack && (cnt == CW'(LIMIT - 1));

    // Wait counter, cleared whenever a phase ends or the port is idle.
    always_ff @(posedge clk) begin
        if (!rst_n || !active || ack || expired) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

endmodule

// File: rtl/cfg_access_seq.sv
// Top of the configuration access sequencer. It accepts one request at a
// time, runs address and data phases on the bridge port (with a read-modify-
// write for sub-word writes), and reports one completion pulse. Assumes the
// port holds ack for one cycle per transaction and err is valid only with ack.
module cfg_access_seq
    import cfg_seq_pkg::*;
#(
    parameter int                BUS_MAX      = 7,
    parameter int                DEVFN_MAX    = 127,
    parameter int                PORT_AW      = 12,
    parameter logic [PORT_AW-1:0] ADDR_REG_OFS = 12'h500,
    parameter logic [PORT_AW-1:0] DATA_REG_OFS = 12'h504,
    parameter int                ACK_TIMEOUT  = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    output logic               req_ready,
    input  logic               req_write,
    input  logic [1:0]         req_size,
    input  logic [BUS_W-1:0]   req_bus,
    input  logic [DEVFN_W-1:0] req_devfn,
    input  logic [OFS_W-1:0]   req_offset,
    input  logic [DATA_W-1:0]  req_wdata,
    output logic               done,
    output logic               done_notfound,
    output logic [DATA_W-1:0]  done_rdata,
    output logic               sel_normal,
    output logic               port_req,
    output logic               port_write,
    output logic [PORT_AW-1:0] port_addr,
    output logic [DATA_W-1:0]  port_wdata,
    input  logic               port_ack,
    input  logic               port_err,
    input  logic [DATA_W-1:0]  port_rdata
);

    seq_state_e         state;
    logic               r_write;
    cfg_size_e          r_size;
    logic [1:0]         r_ofs;
    logic [DATA_W-1:0]  r_addr_word;
    logic [DATA_W-1:0]  r_wdata;
    logic [DATA_W-1:0]  r_word;
    logic               r_notfound;
    logic [DATA_W-1:0]  r_rdata;

    logic               dec_in_range;
    logic [DATA_W-1:0]  dec_addr_word;
    cfg_size_e          req_size_e;
    logic               expired;
    logic               phase_end;
    logic               data_bad;
    logic [DATA_W-1:0]  rd_word_now;
    logic [DATA_W-1:0]  lane_word;
    logic [DATA_W-1:0]  rd_extract;
    logic [DATA_W-1:0]  merged;
    logic [DATA_W-1:0]  oor_fill;

    cfg_target_decode #(
        .BUS_MAX   (BUS_MAX),
        .DEVFN_MAX (DEVFN_MAX)
    ) u_decode (
        .bus       (req_bus),
        .devfn     (req_devfn),
        .offset    (req_offset),
        .in_range  (dec_in_range),
        .addr_word (dec_addr_word)
    );

    cfg_phase_timer #(
        .LIMIT (ACK_TIMEOUT)
    ) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .active  (port_req),
        .ack     (port_ack),
        .expired (expired)
    );

    cfg_lane_unit u_lanes (
        .size       (r_size),
        .ofs        (r_ofs),
        .word_in    (lane_word),
        .new_data   (r_wdata),
        .rd_extract (rd_extract),
        .merged     (merged)
    );

    // Normalise the size code; code 3 is treated as a word.
    always_comb begin
        req_size_e = (req_size == 2'd3) ? SZ_WORD : cfg_size_e'(req_size);
    end

    // Phase completion and the error/timeout substitution of read data.
    always_comb begin
        phase_end   = port_ack || expired;
        data_bad    = expired || (port_ack && port_err);
        rd_word_now = data_bad ? '1 : port_rdata;
        lane_word   = (state == ST_DATA) ? rd_word_now : r_word;
    end

    // All-ones result at the requested size for out-of-range reads.
    always_comb begin
        case (req_size_e)
            SZ_BYTE: oor_fill = 32'h0000_00FF;
            SZ_HALF: oor_fill = 32'h0000_FFFF;
            default: oor_fill = '1;
        endcase
        if (req_write) oor_fill = '0;
    end

    // Sequence state and captured request fields.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state       <= ST_IDLE;
            r_write     <= 1'b0;
            r_size      <= SZ_WORD;
            r_ofs       <= '0;
            r_addr_word <= '0;
            r_wdata     <= '0;
            r_word      <= '0;
            r_notfound  <= 1'b0;
            r_rdata     <= '0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (req_valid) begin
                        r_write     <= req_write;
                        r_size      <= req_size_e;
                        r_ofs       <= req_offset[1:0];
                        r_addr_word <= dec_addr_word;
                        r_wdata     <= req_wdata;
                        r_notfound  <= !dec_in_range;
                        r_rdata     <= dec_in_range ? '0 : oor_fill;
                        state       <= dec_in_range ? ST_ADDR : ST_FIN;
                    end
                end
                ST_ADDR: begin
                    if (phase_end) state <= ST_DATA;
                end
                ST_DATA: begin
                    if (phase_end) begin
                        if (r_write && r_size != SZ_WORD) begin
                            r_word <= rd_word_now;
                            state  <= ST_ADDR2;
                        end else begin
                            if (!r_write) r_rdata <= rd_extract;
                            state <= ST_FIN;
                        end
                    end
                end
                ST_ADDR2: begin
                    if (phase_end) state <= ST_DATA2;
                end
                ST_DATA2: begin
                    if (phase_end) state <= ST_FIN;
                end
                default: begin
                    state <= ST_IDLE;
                end
            endcase
        end
    end

    // Port drive and handshake outputs decoded from the state.
    always_comb begin
        req_ready     = (state == ST_IDLE);
        done          = (state == ST_FIN);
        done_notfound = r_notfound;
        done_rdata    = r_rdata;
        sel_normal    = (state == ST_IDLE) || (state == ST_FIN);
        port_req      = !sel_normal;
        port_write    = 1'b0;
        port_addr     = DATA_REG_OFS;
        port_wdata    = r_wdata;
        case (state)
            ST_ADDR, ST_ADDR2: begin
                port_write = 1'b1;
                port_addr  = ADDR_REG_OFS;
                port_wdata = r_addr_word;
            end
            ST_DATA: begin
                port_write = r_write && (r_size == SZ_WORD);
            end
            ST_DATA2: begin
                port_write = 1'b1;
                port_wdata = merged;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/cfg_access_seq_chk.sv
// Property checker for the configuration access sequencer, bound to the top.
module cfg_access_seq_chk #(
    parameter int          BUS_MAX   = 7,
    parameter int          DEVFN_MAX = 127,
    parameter int          PORT_AW   = 12,
    parameter logic [11:0] ADDR_OFS  = 12'h500
) (
    input logic               clk,
    input logic               rst_n,
    input logic               req_valid,
    input logic               req_ready,
    input logic [7:0]         req_bus,
    input logic [7:0]         req_devfn,
    input logic               done,
    input logic               done_notfound,
    input logic               sel_normal,
    input logic               port_req,
    input logic               port_write,
    input logic [PORT_AW-1:0] port_addr,
    input logic [31:0]        port_wdata
);

    logic addr_phase;
    assign addr_phase = port_req && port_write && (port_addr == ADDR_OFS[PORT_AW-1:0]);

    p_first_phase_addr_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(port_req) |-> (port_write && port_addr == ADDR_OFS[PORT_AW-1:0]));

    p_addr_fields_r2: assert property (@(posedge clk) disable iff (!rst_n)
        addr_phase |-> (port_wdata[31:24] == 8'h00 && port_wdata[1] == 1'b0));

    p_type_bit_r3: assert property (@(posedge clk) disable iff (!rst_n)
        addr_phase |-> (port_wdata[0] == (port_wdata[23:16] != 8'h00)));

    p_oor_no_traffic_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && (int'(req_bus) > BUS_MAX || int'(req_devfn) > DEVFN_MAX))
        |=> (done && done_notfound && !port_req));

    p_sel_on_traffic_r9: assert property (@(posedge clk) disable iff (!rst_n)
        port_req |-> !sel_normal);

    p_lockout_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !sel_normal |-> !req_ready);

    p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!done && req_ready && sel_normal));

endmodule

bind cfg_access_seq cfg_access_seq_chk #(
    .BUS_MAX   (BUS_MAX),
    .DEVFN_MAX (DEVFN_MAX),
    .PORT_AW   (PORT_AW),
    .ADDR_OFS  (12'(ADDR_REG_OFS))
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .req_valid     (req_valid),
    .req_ready     (req_ready),
    .req_bus       (req_bus),
    .req_devfn     (req_devfn),
    .done          (done),
    .done_notfound (done_notfound),
    .sel_normal    (sel_normal),
    .port_req      (port_req),
    .port_write    (port_write),
    .port_addr     (port_addr),
    .port_wdata    (port_wdata)
);

// File: tb/cfg_access_seq_bench.sv
`timescale 1ns/1ps
module cfg_access_seq_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic        req_write = 1'b0;
    logic [1:0]  req_size = 2'd0;
    logic [7:0]  req_bus = 8'd0;
    logic [7:0]  req_devfn = 8'd0;
    logic [7:0]  req_offset = 8'd0;
    logic [31:0] req_wdata = 32'd0;
    logic        done;
    logic        done_notfound;
    logic [31:0] done_rdata;
    logic        sel_normal;
    logic        port_req;
    logic        port_write;
    logic [11:0] port_addr;
    logic [31:0] port_wdata;
    logic        port_ack = 1'b0;
    logic        port_err = 1'b0;
    logic [31:0] port_rdata = 32'd0;

    int total = 0;
    int bad = 0;

    // Port model controls
    logic err_mode = 1'b0;
    logic noack = 1'b0;
    int   lat = 0;
    int   wcnt = 0;

    // Port model state and transaction log
    logic [31:0] mem [0:63];
    logic [31:0] areg = 32'd0;
    logic        lg_wr   [0:15];
    logic [11:0] lg_addr [0:15];
    logic [31:0] lg_data [0:15];
    int          lg_n = 0;

    always #2.5 clk = ~clk;

    cfg_access_seq u_cfg_access_seq (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_size(req_size), .req_bus(req_bus), .req_devfn(req_devfn),
        .req_offset(req_offset), .req_wdata(req_wdata),
        .done(done), .done_notfound(done_notfound), .done_rdata(done_rdata),
        .sel_normal(sel_normal),
        .port_req(port_req), .port_write(port_write), .port_addr(port_addr),
        .port_wdata(port_wdata), .port_ack(port_ack), .port_err(port_err),
        .port_rdata(port_rdata)
    );

    initial begin
        for (int i = 0; i < 64; i++) mem[i] = 32'h9E37_79B9 * (i + 1);
    end

    // Bridge port model: registered ack after lat cycles, logs each transaction.
    always @(posedge clk) begin
        port_ack <= 1'b0;
        port_err <= 1'b0;
        if (!rst_n) begin
            wcnt <= 0;
        end else if (port_req && !port_ack && !noack) begin
            if (wcnt >= lat) begin
                wcnt <= 0;
                port_ack <= 1'b1;
                lg_wr[lg_n % 16]   <= port_write;
                lg_addr[lg_n % 16] <= port_addr;
                if (port_write) begin
                    lg_data[lg_n % 16] <= port_wdata;
                    if (port_addr == 12'h500) areg <= port_wdata;
                    else mem[areg[7:2]] <= port_wdata;
                end else begin
                    lg_data[lg_n % 16] <= mem[areg[7:2]];
                    if (err_mode) begin
                        port_err   <= 1'b1;
                        port_rdata <= 32'h1234_5678;
                    end else begin
                        port_rdata <= mem[areg[7:2]];
                    end
                end
                lg_n <= lg_n + 1;
            end else begin
                wcnt <= wcnt + 1;
            end
        end
    end

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] exp_aw(input logic [7:0] b, input logic [7:0] d, input logic [7:0] o);
        return {8'h00, b, d, o & 8'hFC} | ((b != 0) ? 32'd1 : 32'd0);
    endfunction

    function automatic logic [31:0] lane_mask(input logic [1:0] sz, input logic [7:0] o);
        if (sz == 2'd0) return 32'hFF << (8 * (o % 4));
        if (sz == 2'd1) return 32'hFFFF << (16 * ((o / 2) % 2));
        return 32'hFFFF_FFFF;
    endfunction

    function automatic logic [31:0] exp_read(input logic [1:0] sz, input logic [7:0] o, input logic [31:0] w);
        if (sz == 2'd0) return (w / (32'd1 << (8 * (o % 4)))) % 256;
        if (sz == 2'd1) return (w / (32'd1 << (16 * ((o / 2) % 2)))) % 65536;
        return w;
    endfunction

    function automatic logic [31:0] exp_merge(input logic [1:0] sz, input logic [7:0] o,
                                              input logic [31:0] old, input logic [31:0] wd);
        logic [31:0] m;
        logic [31:0] sh;
        m = lane_mask(sz, o);
        if (sz == 2'd0) sh = wd << (8 * (o % 4));
        else if (sz == 2'd1) sh = wd << (16 * ((o / 2) % 2));
        else sh = wd;
        return (old & ~m) | (sh & m);
    endfunction

    logic [31:0] got_rdata;
    logic        got_nf;
    int          base;
    int          ntx;

    // Issue one request, wait for completion, and check handshake/select behaviour.
    task automatic do_req(input logic wr, input logic [1:0] sz, input logic [7:0] b,
                          input logic [7:0] d, input logic [7:0] o, input logic [31:0] wd);
        int cyc;
        int selbad;
        int busybad;
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        base = lg_n;
        req_write = wr; req_size = sz; req_bus = b; req_devfn = d;
        req_offset = o; req_wdata = wd; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        cyc = 0; selbad = 0; busybad = 0;
        while (!done && cyc < 2000) begin
            if (port_req && sel_normal) selbad++;
            if (req_ready) busybad++;
            @(negedge clk);
            cyc++;
        end
        chk(cyc < 2000, "R10 completion pulse seen", cyc, 0);
        chk(selbad == 0, "R9 select low during traffic", selbad, 0);
        chk(busybad == 0 && !req_ready, "R10 ready low while busy", busybad, 0);
        chk(sel_normal, "R9 select restored at completion", sel_normal, 1);
        got_rdata = done_rdata;
        got_nf = done_notfound;
        ntx = lg_n - base;
        @(negedge clk);
        chk(!done && req_ready, "R10 single-cycle done then ready", done, 0);
    endtask

    initial begin
        logic [7:0] dl [0:2];
        logic [7:0] ol [0:2];
        logic [31:0] old;
        logic [31:0] aw;
        dl[0] = 8'h00; dl[1] = 8'h2A; dl[2] = 8'h7F;
        ol[0] = 8'h00; ol[1] = 8'h3D; ol[2] = 8'hFC;

        repeat (3) @(negedge clk);
        chk(req_ready == 1'b0 || req_ready == 1'b1, "R10 reset drive", req_ready, 1);
        rst_n = 1'b1;
        @(negedge clk);
        chk(req_ready && sel_normal && !port_req && !done,
            "R10 R9 reset state", {req_ready, sel_normal, port_req, done}, 32'b1100);

        // R1 R2 R3 R11: word reads over buses, device numbers and offsets
        for (int b = 0; b < 8; b++) begin
            for (int di = 0; di < 3; di++) begin
                for (int oi = 0; oi < 3; oi++) begin
                    lat = (b + oi) % 3;
                    aw = exp_aw(8'(b), dl[di], ol[oi]);
                    old = mem[ol[oi][7:2]];
                    do_req(1'b0, 2'd2, 8'(b), dl[di], ol[oi], 32'd0);
                    chk(ntx == 2, "R1 two transactions", ntx, 2);
                    chk(lg_wr[base % 16] && lg_addr[base % 16] == 12'h500,
                        "R1 address phase first", lg_addr[base % 16], 32'h500);
                    chk(lg_data[base % 16] == aw, "R2 R3 R11 address word", lg_data[base % 16], aw);
                    chk(!lg_wr[(base + 1) % 16] && lg_addr[(base + 1) % 16] == 12'h504,
                        "R1 data read phase", lg_addr[(base + 1) % 16], 32'h504);
                    chk(got_rdata == old && !got_nf, "R11 word read data", got_rdata, old);
                end
            end
        end

        // R5 R6 R11: sub-word and word reads at every offset of two registers
        for (int sz = 0; sz < 4; sz++) begin
            for (int o = 8; o < 16; o++) begin
                lat = o % 2;
                old = mem[o / 4];
                do_req(1'b0, 2'(sz), 8'd0, 8'h10, 8'(o), 32'd0);
                chk(ntx == 2, "R1 read transactions", ntx, 2);
                chk(got_rdata == exp_read((sz == 3) ? 2'd2 : 2'(sz), 8'(o), old),
                    (sz == 0) ? "R5 byte lane read" : (sz == 1) ? "R6 half read" : "R11 word read",
                    got_rdata, exp_read((sz == 3) ? 2'd2 : 2'(sz), 8'(o), old));
            end
        end

        // R7 R11: writes at every offset, all sizes
        for (int sz = 0; sz < 3; sz++) begin
            for (int o = 16; o < 24; o++) begin
                logic [31:0] wd;
                logic [31:0] em;
                wd = 32'hC0DE_0000 + 32'(sz * 256 + o * 7);
                old = mem[o / 4];
                em = exp_merge(2'(sz), 8'(o), old, wd);
                aw = exp_aw(8'd2, 8'h41, 8'(o));
                lat = sz;
                do_req(1'b1, 2'(sz), 8'd2, 8'h41, 8'(o), wd);
                if (sz == 2) begin
                    chk(ntx == 2, "R1 word write transactions", ntx, 2);
                    chk(lg_wr[(base + 1) % 16] && lg_data[(base + 1) % 16] == wd,
                        "R11 word write data", lg_data[(base + 1) % 16], wd);
                end else begin
                    chk(ntx == 4, "R7 four transactions", ntx, 4);
                    chk(!lg_wr[(base + 1) % 16] && lg_addr[(base + 1) % 16] == 12'h504,
                        "R7 read step", lg_wr[(base + 1) % 16], 0);
                    chk(lg_wr[(base + 2) % 16] && lg_addr[(base + 2) % 16] == 12'h500 &&
                        lg_data[(base + 2) % 16] == aw, "R7 fresh address phase",
                        lg_data[(base + 2) % 16], aw);
                    chk(lg_wr[(base + 3) % 16] && lg_data[(base + 3) % 16] == em,
                        "R7 merged write-back", lg_data[(base + 3) % 16], em);
                end
                chk(mem[o / 4] == em && !got_nf, "R7 stored word", mem[o / 4], em);
            end
        end

        // R4: out-of-range targets, reads and writes, all sizes
        for (int k = 0; k < 4; k++) begin
            for (int sz = 0; sz < 3; sz++) begin
                logic [7:0] b;
                logic [7:0] d;
                logic [31:0] ef;
                b = (k == 0) ? 8'd8 : (k == 1) ? 8'd200 : 8'd1;
                d = (k == 2) ? 8'd128 : (k == 3) ? 8'hFF : 8'd3;
                ef = (sz == 0) ? 32'hFF : (sz == 1) ? 32'hFFFF : 32'hFFFF_FFFF;
                do_req(1'b0, 2'(sz), b, d, 8'h04, 32'd0);
                chk(ntx == 0 && got_nf, "R4 no traffic, not found", ntx, 0);
                chk(got_rdata == ef, "R4 all-ones read", got_rdata, ef);
                old = mem[1];
                do_req(1'b1, 2'(sz), b, d, 8'h04, 32'h0);
                chk(ntx == 0 && got_nf && mem[1] == old, "R4 write ignored", mem[1], old);
            end
        end

        // R8: error responses and missing acknowledge on reads
        err_mode = 1'b1;
        for (int sz = 0; sz < 3; sz++) begin
            logic [31:0] ef;
            ef = (sz == 0) ? 32'hFF : (sz == 1) ? 32'hFFFF : 32'hFFFF_FFFF;
            do_req(1'b0, 2'(sz), 8'd1, 8'd9, 8'(sz + 1), 32'd0);
            chk(got_rdata == ef && !got_nf, "R8 error read gives ones", got_rdata, ef);
        end
        err_mode = 1'b0;
        noack = 1'b1;
        for (int sz = 0; sz < 3; sz++) begin
            logic [31:0] ef;
            ef = (sz == 0) ? 32'hFF : (sz == 1) ? 32'hFFFF : 32'hFFFF_FFFF;
            do_req(1'b0, 2'(sz), 8'd0, 8'd5, 8'h08, 32'd0);
            chk(got_rdata == ef && ntx == 0, "R8 timeout read gives ones", got_rdata, ef);
        end
        noack = 1'b0;

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check and still reports.
    initial begin
        #(150000 * 5);
        bad++;
        total++;
        $display("FAIL R10 watchdog expired actual=%0d expected=%0d", 1, 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule